// File: doc/BRIEF.md
# Keyed Nonvolatile Write-Unlock Controller

This block sits between a CPU register bus and the command port of a nonvolatile memory array. Software selects the target space, fills a 22-bit address pointer and sets a write-enable bit. A program or erase operation then starts only when the start bit is written straight after a two-write key sequence (0x55, then 0xAA) to a key location that stores nothing. While the array works, the CPU is held with a stall output. Completion clears the start bit in hardware and raises a sticky completion flag.

A run that is cut short by a system reset (external pin or watchdog) leaves a write-error bit set. That bit survives the system reset, so software can detect the loss and retry. Only a power-on reset clears it without software. Single-cycle array reads into a data latch need no key sequence.

Register map (busAddr): 0 control, 1 key, 2 pointer bits 7:0, 3 pointer bits 15:8, 4 pointer bits 21:16, 5 read latch, 6 status. Control bits: 7 program-memory select, 6 configuration-space select, 5 unused, 4 erase select, 3 write error, 2 write enable, 1 write start, 0 read start.

Top module: `nvmkg_top`

## Requirements
- R1: After power-on reset, the control, status and pointer registers read 0, and cpuStall, cmdStart, cmdRead and doneIrq are 0.
- R2: After key writes 0x55 then 0xAA to address 1, a control write with bit 1 set (and write enable already 1) sets the start bit. In the cycle after that write, cmdStart pulses for one cycle and cpuStall goes high. cmdProgMem and cmdErase follow control bits 7 and 4.
- R3: Reads of the key address return 0, and writes to it change no readable register.
- R4: A start attempt is ignored unless write enable (control bit 2) was already 1 before that same write.
- R5: The unlock is lost when another bus write comes between the two keys, or when a key value is wrong. The first control write after an unlock also consumes it, whether or not that write starts an operation.
- R6: cpuStall and control bit 1 stay high until arrDone is seen. A software write of 0 to bit 1 does not clear them. On arrDone both clear in the next cycle.
- R7: arrDone during an operation sets doneIrq. doneIrq stays set until software writes 0 to bit 0 of status address 6.
- R8: A system reset (sysRstN low) during an operation sets write error (control bit 3). That bit survives further system resets and can be cleared by writing 0 to it. A system reset clears every other register. Power-on reset clears write error.
- R9: The pointer is 22 bits wide, and bits 7:6 of address 4 read 0. cmdAddr presents the pointer. cmdCfgSpace is high when control bit 6 or pointer bit 21 is set.
- R10: A control write with bit 0 set pulses cmdRead for one cycle without any unlock. At the following clock edge, arrRdData is captured into the latch at address 5, and bit 0 reads 0 again.
- R11: Control bit 5 always reads 0. Bit 3 cannot be set by software, and bit 1 cannot be set without an unlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, active low, asynchronous |
| sysRstN | input | 1 | External or watchdog reset, active low, synchronous |
| busWrEn | input | 1 | Bus write strobe |
| busRdEn | input | 1 | Bus read enable |
| busAddr | input | 3 | Register address |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, 0 when busRdEn is low |
| cmdStart | output | 1 | One-cycle operation start |
| cmdErase | output | 1 | Erase (1) or program (0) |
| cmdProgMem | output | 1 | Program memory (1) or data memory (0) |
| cmdCfgSpace | output | 1 | Configuration space select |
| cmdAddr | output | 22 | Target address |
| cmdRead | output | 1 | One-cycle array read strobe |
| arrRdData | input | 8 | Array read data |
| arrDone | input | 1 | Array operation complete |
| cpuStall | output | 1 | CPU stall while an operation runs |
| doneIrq | output | 1 | Sticky completion flag |

## Verification
The hardest state to reach is a write error: it needs an operation actually in flight when a system reset lands. The bench therefore runs a full legal unlock and start, holds arrDone low, and pulses sysRstN while cpuStall is high. It then pulses sysRstN again and applies a power-on reset, to show that the flag persists through the first and clears only on the second. The key-sequence breakers come from directed write orders: an intervening pointer write, a wrong second key, and a plain control write that consumes the unlock. Each is followed by a start attempt whose effect is read back through cpuStall and control bit 1.

// File: rtl/nvmkg_pkg.sv
package nvmkg_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_KEY   = 3'd1;
  localparam logic [ADDR_W-1:0] A_PTRLO = 3'd2;
  localparam logic [ADDR_W-1:0] A_PTRMD = 3'd3;
  localparam logic [ADDR_W-1:0] A_PTRUP = 3'd4;
  localparam logic [ADDR_W-1:0] A_LATCH = 3'd5;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd6;

  localparam logic [DATA_W-1:0] KEY_FIRST  = 8'h55;
  localparam logic [DATA_W-1:0] KEY_SECOND = 8'hAA;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_HALF  = 2'd1,
    SEQ_ARMED = 2'd2
  } seqState_t;

  typedef struct packed {
    logic wrFields;
    logic wrPtrLo;
    logic wrPtrMd;
    logic wrPtrUp;
    logic capture;
  } dpStrobe_t;
endpackage

// File: rtl/nvmkg_ctrl.sv
module nvmkg_ctrl
  import nvmkg_pkg::*;
(
  input  logic              clk,
  input  logic              porRstN,
  input  logic              sysRstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              wrEnBit,
  input  logic              arrDone,
  output dpStrobe_t         strobe,
  output logic              wrStart,
  output logic              rdStart,
  output logic              wrErr,
  output logic              doneFlag,
  output logic              cmdStart
);
  seqState_t seq;
  logic ctrlWr, keyWr, statWr, startReq, opDone;

  assign ctrlWr = busWrEn && (busAddr == A_CTRL);
  assign keyWr  = busWrEn && (busAddr == A_KEY);
  assign statWr = busWrEn && (busAddr == A_STAT);
  assign startReq = ctrlWr && busWrData[1] && (seq == SEQ_ARMED) && wrEnBit && !wrStart;
  assign opDone = arrDone && wrStart;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) seq <= SEQ_IDLE;
    else if (!sysRstN) seq <= SEQ_IDLE;
    else if (keyWr) begin
      if (busWrData == KEY_FIRST) seq <= SEQ_HALF;
      else if (seq == SEQ_HALF && busWrData == KEY_SECOND) seq <= SEQ_ARMED;
      else seq <= SEQ_IDLE;
    end else if (busWrEn) seq <= SEQ_IDLE;
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      wrStart  <= 1'b0;
      cmdStart <= 1'b0;
      rdStart  <= 1'b0;
      doneFlag <= 1'b0;
    end else if (!sysRstN) begin
      wrStart  <= 1'b0;
      cmdStart <= 1'b0;
      rdStart  <= 1'b0;
      doneFlag <= 1'b0;
    end else begin
      cmdStart <= startReq;
      if (startReq) wrStart <= 1'b1;
      else if (opDone) wrStart <= 1'b0;
      rdStart <= ctrlWr && busWrData[0] && !wrStart && !rdStart;
      if (opDone) doneFlag <= 1'b1;
      else if (statWr && !busWrData[0]) doneFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) wrErr <= 1'b0;
    else if (!sysRstN) begin
      if (wrStart) wrErr <= 1'b1;
    end else if (ctrlWr) wrErr <= wrErr & busWrData[3];
  end

  always_comb begin
    strobe.wrFields = ctrlWr;
    strobe.wrPtrLo  = busWrEn && (busAddr == A_PTRLO);
    strobe.wrPtrMd  = busWrEn && (busAddr == A_PTRMD);
    strobe.wrPtrUp  = busWrEn && (busAddr == A_PTRUP);
    strobe.capture  = rdStart;
  end
endmodule

// File: rtl/nvmkg_dpath.sv
module nvmkg_dpath
  import nvmkg_pkg::*;
#(
  parameter int PTR_W = 22
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              sysRstN,
  input  dpStrobe_t         strobe,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [DATA_W-1:0] arrRdData,
  input  logic              wrStart,
  input  logic              rdStart,
  input  logic              wrErr,
  input  logic              doneFlag,
  output logic              wrEnBit,
  output logic              cmdErase,
  output logic              cmdProgMem,
  output logic              cmdCfgSpace,
  output logic [PTR_W-1:0]  cmdAddr,
  output logic [DATA_W-1:0] busRdData
);
  localparam int UP_W = PTR_W - 2*DATA_W;

  logic memSel, cfgSel, eraseSel, wrEnReg;
  logic [DATA_W-1:0] ptrLo, ptrMd, latchQ;
  logic [UP_W-1:0]   ptrUp;
  logic [DATA_W-1:0] ctrlView, rdMux;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      memSel <= 1'b0; cfgSel <= 1'b0; eraseSel <= 1'b0; wrEnReg <= 1'b0;
      ptrLo <= '0; ptrMd <= '0; ptrUp <= '0; latchQ <= '0;
    end else if (!sysRstN) begin
      memSel <= 1'b0; cfgSel <= 1'b0; eraseSel <= 1'b0; wrEnReg <= 1'b0;
      ptrLo <= '0; ptrMd <= '0; ptrUp <= '0; latchQ <= '0;
    end else begin
      if (strobe.wrFields) begin
        memSel   <= busWrData[7];
        cfgSel   <= busWrData[6];
        eraseSel <= busWrData[4];
        wrEnReg  <= busWrData[2];
      end
      if (strobe.wrPtrLo) ptrLo <= busWrData;
      if (strobe.wrPtrMd) ptrMd <= busWrData;
      if (strobe.wrPtrUp) ptrUp <= busWrData[UP_W-1:0];
      if (strobe.capture) latchQ <= arrRdData;
    end
  end

  assign wrEnBit     = wrEnReg;
  assign cmdErase    = eraseSel;
  assign cmdProgMem  = memSel;
  assign cmdAddr     = {ptrUp, ptrMd, ptrLo};
  assign cmdCfgSpace = cfgSel | ptrUp[UP_W-1];

  assign ctrlView = {memSel, cfgSel, 1'b0, eraseSel, wrErr, wrEnReg, wrStart, rdStart};

  always_comb begin
    case (busAddr)
      A_CTRL:  rdMux = ctrlView;
      A_PTRLO: rdMux = ptrLo;
      A_PTRMD: rdMux = ptrMd;
      A_PTRUP: rdMux = {{(DATA_W-UP_W){1'b0}}, ptrUp};
      A_LATCH: rdMux = latchQ;
      A_STAT:  rdMux = {{(DATA_W-1){1'b0}}, doneFlag};
      default: rdMux = '0;
    endcase
  end

  assign busRdData = busRdEn ? rdMux : '0;
endmodule

// File: rtl/nvmkg_top.sv
module nvmkg_top
  import nvmkg_pkg::*;
#(
  parameter int PTR_W = 22
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              sysRstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              cmdStart,
  output logic              cmdErase,
  output logic              cmdProgMem,
  output logic              cmdCfgSpace,
  output logic [PTR_W-1:0]  cmdAddr,
  output logic              cmdRead,
  input  logic [DATA_W-1:0] arrRdData,
  input  logic              arrDone,
  output logic              cpuStall,
  output logic              doneIrq
);
  dpStrobe_t strobe;
  logic wrStart, rdStart, wrErr, doneFlag, wrEnBit;

  nvmkg_ctrl u_ctrl (
    .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN),
    .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData),
    .wrEnBit(wrEnBit), .arrDone(arrDone), .strobe(strobe),
    .wrStart(wrStart), .rdStart(rdStart), .wrErr(wrErr),
    .doneFlag(doneFlag), .cmdStart(cmdStart)
  );

  nvmkg_dpath #(.PTR_W(PTR_W)) u_dpath (
    .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN), .strobe(strobe),
    .busRdEn(busRdEn), .busAddr(busAddr), .busWrData(busWrData),
    .arrRdData(arrRdData), .wrStart(wrStart), .rdStart(rdStart),
    .wrErr(wrErr), .doneFlag(doneFlag), .wrEnBit(wrEnBit),
    .cmdErase(cmdErase), .cmdProgMem(cmdProgMem), .cmdCfgSpace(cmdCfgSpace),
    .cmdAddr(cmdAddr), .busRdData(busRdData)
  );

  assign cpuStall = wrStart;
  assign cmdRead  = rdStart;
  assign doneIrq  = doneFlag;
endmodule

// File: rtl/nvmkg_checker.sv
module nvmkg_checker
  import nvmkg_pkg::*;
(
  input logic              clk,
  input logic              porRstN,
  input logic              sysRstN,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWrData,
  input logic [DATA_W-1:0] busRdData,
  input logic              cmdStart,
  input logic              cmdRead,
  input logic              arrDone,
  input logic              cpuStall,
  input logic              doneIrq
);
  assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    cmdStart |=> !cmdStart);
  assert_start_stalls_R2: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    cmdStart |-> cpuStall);
  assert_start_source_R5: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    $rose(cpuStall) |-> $past(busWrEn) && $past(busAddr) == A_CTRL && $past(busWrData[1]));
  assert_key_reads_zero_R3: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    (busRdEn && busAddr == A_KEY) |-> busRdData == '0);
  assert_done_release_R6: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    (arrDone && cpuStall) |=> !cpuStall && doneIrq);
  assert_read_pulse_R10: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    cmdRead |=> !cmdRead);
endmodule

bind nvmkg_top nvmkg_checker u_chk (
  .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN), .busWrEn(busWrEn),
  .busRdEn(busRdEn), .busAddr(busAddr), .busWrData(busWrData),
  .busRdData(busRdData), .cmdStart(cmdStart), .cmdRead(cmdRead),
  .arrDone(arrDone), .cpuStall(cpuStall), .doneIrq(doneIrq)
);

// File: tb/nvmkg_top_bench.sv
module nvmkg_top_bench;
  logic clk = 1'b0;
  logic porRstN = 1'b0, sysRstN = 1'b1;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic cmdStart, cmdErase, cmdProgMem, cmdCfgSpace, cmdRead, cpuStall, doneIrq;
  logic [21:0] cmdAddr;
  logic [7:0] arrRdData;
  logic arrDone = 1'b0;
  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;
  assign arrRdData = cmdAddr[7:0] ^ 8'h3C;

  nvmkg_top u_nvmkg_top (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk); busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    busRdEn = 1'b1; busAddr = a; #1 d = busRdData; busRdEn = 1'b0;
  endtask

  task automatic unlock();
    wr(3'd1, 8'h55); wr(3'd1, 8'hAA);
  endtask

  task automatic porPulse();
    @(negedge clk); porRstN = 1'b0; repeat (2) @(negedge clk); porRstN = 1'b1;
  endtask

  task automatic sysPulse();
    @(negedge clk); sysRstN = 1'b0; @(negedge clk); sysRstN = 1'b1;
  endtask

  task automatic finishOp();
    @(negedge clk); arrDone = 1'b1; @(negedge clk); arrDone = 1'b0;
  endtask

  task automatic test_reset();
    logic [7:0] v;
    porPulse();
    rd(3'd0, v); check("R1 ctrl", v, 8'h00);
    rd(3'd6, v); check("R1 status", v, 8'h00);
    rd(3'd2, v); check("R1 ptr", v, 8'h00);
    check("R1 outputs", {cpuStall, cmdStart, cmdRead, doneIrq}, 4'b0);
  endtask

  task automatic test_start_done();
    logic [7:0] v;
    wr(3'd0, 8'h94);
    unlock();
    rd(3'd1, v); check("R3 key reads 0", v, 8'h00);
    rd(3'd0, v); check("R3 key write no effect", v, 8'h94);
    wr(3'd0, 8'h96);
    check("R2 start pulse and stall", {cmdStart, cpuStall, cmdProgMem, cmdErase}, 4'b1111);
    @(negedge clk); check("R2 start one cycle", cmdStart, 1'b0);
    wr(3'd0, 8'h94);
    rd(3'd0, v); check("R6 start bit not cleared by software", v[1], 1'b1);
    check("R6 stall held", cpuStall, 1'b1);
    finishOp();
    check("R6 stall released", cpuStall, 1'b0);
    check("R7 irq set", doneIrq, 1'b1);
    rd(3'd0, v); check("R6 start bit cleared", v[1], 1'b0);
    wr(3'd6, 8'h01); check("R7 irq kept on write 1", doneIrq, 1'b1);
    wr(3'd6, 8'h00); check("R7 irq cleared", doneIrq, 1'b0);
  endtask

  task automatic test_wren();
    wr(3'd0, 8'h00);
    unlock();
    wr(3'd0, 8'h06);
    check("R4 start needs prior enable", {cpuStall, cmdStart}, 2'b00);
  endtask

  task automatic test_broken_seq();
    wr(3'd0, 8'h04);
    wr(3'd1, 8'h55); wr(3'd2, 8'h00); wr(3'd1, 8'hAA); wr(3'd0, 8'h06);
    check("R5 intervening write", cpuStall, 1'b0);
    wr(3'd1, 8'h55); wr(3'd1, 8'hA5); wr(3'd1, 8'hAA); wr(3'd0, 8'h06);
    check("R5 wrong key", cpuStall, 1'b0);
    unlock(); wr(3'd0, 8'h04); wr(3'd0, 8'h06);
    check("R5 unlock consumed", cpuStall, 1'b0);
  endtask

  task automatic test_abort();
    logic [7:0] v;
    wr(3'd0, 8'h04); unlock(); wr(3'd0, 8'h06);
    check("R8 op running", cpuStall, 1'b1);
    sysPulse();
    check("R8 stall cleared by sys reset", cpuStall, 1'b0);
    rd(3'd0, v); check("R8 error set", v, 8'h08);
    sysPulse();
    rd(3'd0, v); check("R8 error survives sys reset", v, 8'h08);
    wr(3'd0, 8'h08); rd(3'd0, v); check("R8 error kept on write 1", v, 8'h08);
    wr(3'd0, 8'h00); rd(3'd0, v); check("R8 error cleared by software", v, 8'h00);
    wr(3'd0, 8'h04); unlock(); wr(3'd0, 8'h06); sysPulse();
    porPulse();
    rd(3'd0, v); check("R8 power-on clears error", v, 8'h00);
  endtask

  task automatic test_pointer();
    logic [7:0] v;
    wr(3'd2, 8'h34); wr(3'd3, 8'h12); wr(3'd4, 8'hFF);
    rd(3'd4, v); check("R9 upper byte bits 7:6 zero", v, 8'h3F);
    check("R9 cmdAddr", cmdAddr, 22'h3F1234);
    check("R9 cfg space via bit 21", cmdCfgSpace, 1'b1);
    wr(3'd4, 8'h01); check("R9 cfg space off", cmdCfgSpace, 1'b0);
    wr(3'd0, 8'h40); check("R9 cfg space via ctrl", cmdCfgSpace, 1'b1);
  endtask

  task automatic test_read();
    logic [7:0] v;
    wr(3'd2, 8'h12);
    wr(3'd0, 8'h01);
    check("R10 read strobe", cmdRead, 1'b1);
    @(negedge clk);
    check("R10 read strobe one cycle", cmdRead, 1'b0);
    rd(3'd5, v); check("R10 latch", v, 8'h2E);
    rd(3'd0, v); check("R10 read bit self-clear", v[0], 1'b0);
  endtask

  task automatic test_reserved();
    logic [7:0] v;
    wr(3'd0, 8'hFF);
    @(negedge clk);
    rd(3'd0, v); check("R11 reserved and protected bits", v, 8'hD4);
    check("R11 no start without unlock", cpuStall, 1'b0);
  endtask

  initial begin
    test_reset();
    test_start_done();
    test_wren();
    test_broken_seq();
    test_abort();
    test_pointer();
    test_read();
    test_reserved();
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule